// File: doc/BRIEF.md
# EDO DRAM Single-Word Access Controller

This controller connects a synchronous host port to an asynchronous EDO DRAM with a 16-bit data word and 18 address bits. The DRAM has a shared data bus that both sides drive at different times. The host raises a request together with a write flag, a word address, write data and two byte enables. It keeps all of these steady until the controller answers with a one-cycle done pulse. On a read, the data is valid in the same cycle as that pulse. The controller turns each request into one DRAM access. The row is sent first on the shared address pins, then the column. Each byte lane has its own CAS strobe. Writes are always early writes.

Before the first access, the controller waits out the power-up pause and then runs the wake-up sequence of CAS-before-RAS refreshes. After that, a timer asks for one refresh each interval. A refresh that is due wins over a waiting host request, but an access that has already started always finishes first. If too many cycles ever pass without a refresh, the whole wake-up sequence runs again before host traffic resumes. Every DRAM timing is a parameter counted in clock cycles.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, RAS, both CAS strobes, WE and OE are all high (inactive), done is low and the data bus is not driven.
- R2: No strobe falls until PAUSE_CYC cycles after reset. After that, exactly WAKE_N CAS-before-RAS refreshes run, spaced T_CSR+T_RAS+T_RP+1 cycles apart, before the first host access. A request raised during this time is held off, not lost.
- R3: In a refresh, both CAS strobes fall while RAS is high, at least T_CSR cycles before RAS falls.
- R4: With the host idle, the start of one refresh (its CAS fall) and the start of the next are exactly REF_INTERVAL cycles apart.
- R5: If REF_LAPSE cycles pass without a refresh starting, WAKE_N refreshes run back to back again before any host access. The gap before that burst is at least REF_LAPSE cycles.
- R6: When RAS falls, the address pins carry the row, which is address bits 17:9. When the CAS strobes fall, the address pins carry the column, which is address bits 8:0.
- R7: On a write, WE is low at least one cycle before any CAS strobe falls. OE stays high for the whole cycle. The controller drives the data bus only during write cycles.
- R8: The lower CAS strobe, which covers data bits 7:0, falls only when byte enable bit 0 is set. The upper CAS strobe, which covers bits 15:8, falls only when bit 1 is set. A byte lane that is not enabled is left unchanged in the DRAM.
- R9: On a read, OE is low while CAS is low. Read data is captured after CAS has been low for max(T_CAS, T_CAC, T_RAS-T_RCD) cycles. A lane that is not enabled reads as zero.
- R10: Every access holds RAS low for at least T_RAS cycles and RAS high for at least T_RP cycles between cycles. It waits at least T_RCD cycles from the RAS fall to the CAS fall and holds each CAS low for at least T_CAS cycles.
- R11: Under back-to-back host traffic, the gap between refresh starts never exceeds REF_INTERVAL plus one full access plus one cycle.
- R12: Each accepted request produces exactly one done pulse, one cycle wide. Results come back in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Request; held high with all fields stable until done |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address: row in bits 17:9, column in bits 8:0 |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables: bit 0 covers data bits 7:0, bit 1 covers bits 15:8 |
| host_rdata | output | 16 | Read data, valid with done |
| host_done | output | 1 | One-cycle completion pulse |
| dram_a | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_casl_n | output | 1 | Lower-byte column strobe, active low |
| dram_cash_n | output | 1 | Upper-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq | inout | 16 | Bidirectional data bus |

## Verification
The properties assume the host keeps the request and its fields stable from the rise of the request until done. They also assume the DRAM drives the bus only while OE, RAS and the lane's CAS are all low. The bench host waits for each done pulse before it drops the request and loads the next one. The bench DRAM model drives a lane only under that three-strobe condition, so the bus never has two drivers. The strobe-width and refresh-ordering properties further rely on T_RCD being at least 2 and on every timing parameter being at least 1, and both parameter sets in the bench respect that.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ROW, ST_COL, ST_PRE, ST_RF_CAS, ST_RF_RAS, ST_RF_PRE
  } edo_state_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/edo_hold_timer.sv
module edo_hold_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= len - W'(1);
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/edo_refresh_sched.sv
module edo_refresh_sched #(
  parameter int PAUSE_CYC    = 50000,
  parameter int WAKE_N       = 8,
  parameter int REF_INTERVAL = 3900,
  parameter int REF_LAPSE    = 7800
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_start,
  output logic ref_due,
  output logic wake_busy
);
  localparam int PW      = $clog2(PAUSE_CYC + 1);
  localparam int AGE_MAX = (REF_INTERVAL > REF_LAPSE) ? REF_INTERVAL : REF_LAPSE;
  localparam int AGW     = $clog2(AGE_MAX + 1);
  localparam int WNW     = $clog2(WAKE_N + 1);

  logic [PW-1:0]  pause_cnt;
  logic [AGW-1:0] age;
  logic [WNW-1:0] wake_left;
  logic           pause_done;

  assign pause_done = (pause_cnt == PW'(PAUSE_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      pause_cnt <= '0;
      age       <= '0;
      wake_left <= WNW'(WAKE_N);
    end else begin
      if (!pause_done) pause_cnt <= pause_cnt + PW'(1);

      if (ref_start)                              age <= '0;
      else if (pause_done && age != AGW'(AGE_MAX)) age <= age + AGW'(1);

      if (ref_start && wake_left != '0)
        wake_left <= wake_left - WNW'(1);
      else if (pause_done && wake_left == '0 && age >= AGW'(REF_LAPSE))
        wake_left <= WNW'(WAKE_N);
    end
  end

  assign ref_due   = pause_done && ((wake_left != '0) || (age >= AGW'(REF_INTERVAL - 1)));
  assign wake_busy = !pause_done || (wake_left != '0);
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W        = 9,
  parameter int COL_W        = 9,
  parameter int LANE_W       = 8,
  parameter int PAUSE_CYC    = 50000,
  parameter int WAKE_N       = 8,
  parameter int REF_INTERVAL = 3900,
  parameter int REF_LAPSE    = 7800,
  parameter int T_RCD        = 3,
  parameter int T_CAS        = 3,
  parameter int T_CAC        = 4,
  parameter int T_RAS        = 8,
  parameter int T_RP         = 4,
  parameter int T_CSR        = 2,
  localparam int AW   = ROW_W + COL_W,
  localparam int DW   = 2 * LANE_W,
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic [1:0]    host_be,
  output logic [DW-1:0] host_rdata,
  output logic          host_done,
  output logic [MA_W-1:0] dram_a,
  output logic          dram_ras_n,
  output logic          dram_casl_n,
  output logic          dram_cash_n,
  output logic          dram_we_n,
  output logic          dram_oe_n,
  inout  wire  [DW-1:0] dram_dq
);
  // CAS stays low long enough for access time and for the RAS minimum.
  localparam int CAS_HOLD = imax(imax(T_CAS, T_CAC), T_RAS - T_RCD);
  localparam int TMAX     = imax(imax(imax(T_RCD, CAS_HOLD), imax(T_RP, T_RAS)), T_CSR);
  localparam int TW       = $clog2(TMAX + 1);

  edo_state_e    state, nxt;
  logic          t_load, t_exp, ref_start, accept;
  logic [TW-1:0] t_len;
  logic          ref_due, wake_busy;
  logic [AW-1:0] addr_q;
  logic          we_q;
  logic [1:0]    be_q;
  logic [DW-1:0] dq_q, rd_masked;
  logic          dq_oe;

  edo_hold_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .len(t_len), .expired(t_exp)
  );

  edo_refresh_sched #(
    .PAUSE_CYC(PAUSE_CYC), .WAKE_N(WAKE_N),
    .REF_INTERVAL(REF_INTERVAL), .REF_LAPSE(REF_LAPSE)
  ) u_sched (
    .clk(clk), .rst(rst), .ref_start(ref_start),
    .ref_due(ref_due), .wake_busy(wake_busy)
  );

  // Bus driven only for writes; lanes masked on read capture.
  assign dram_dq = dq_oe ? dq_q : {DW{1'bz}};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign rd_masked[g*LANE_W +: LANE_W] = be_q[g] ? dram_dq[g*LANE_W +: LANE_W] : '0;
  end

  always_comb begin
    nxt       = state;
    t_load    = 1'b0;
    t_len     = TW'(1);
    ref_start = 1'b0;
    accept    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (ref_due) begin
          nxt = ST_RF_CAS; t_load = 1'b1; t_len = TW'(T_CSR); ref_start = 1'b1;
        end else if (host_req && !wake_busy) begin
          nxt = ST_ROW; t_load = 1'b1; t_len = TW'(T_RCD); accept = 1'b1;
        end
      end
      ST_ROW:    if (t_exp) begin nxt = ST_COL;    t_load = 1'b1; t_len = TW'(CAS_HOLD); end
      ST_COL:    if (t_exp) begin nxt = ST_PRE;    t_load = 1'b1; t_len = TW'(T_RP);     end
      ST_PRE:    if (t_exp) nxt = ST_IDLE;
      ST_RF_CAS: if (t_exp) begin nxt = ST_RF_RAS; t_load = 1'b1; t_len = TW'(T_RAS);    end
      ST_RF_RAS: if (t_exp) begin nxt = ST_RF_PRE; t_load = 1'b1; t_len = TW'(T_RP);     end
      ST_RF_PRE: if (t_exp) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      dram_ras_n  <= 1'b1;
      dram_casl_n <= 1'b1;
      dram_cash_n <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_a      <= '0;
      dq_oe       <= 1'b0;
      dq_q        <= '0;
      addr_q      <= '0;
      we_q        <= 1'b0;
      be_q        <= '0;
      host_rdata  <= '0;
      host_done   <= 1'b0;
    end else begin
      state     <= nxt;
      host_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ref_start) begin
            dram_casl_n <= 1'b0;
            dram_cash_n <= 1'b0;
          end else if (accept) begin
            addr_q     <= host_addr;
            we_q       <= host_we;
            be_q       <= host_be;
            dq_q       <= host_wdata;
            dram_a     <= MA_W'(host_addr[AW-1:COL_W]);
            dram_ras_n <= 1'b0;
            dram_we_n  <= !host_we;
            dq_oe      <= host_we;
          end
        end
        ST_ROW: begin
          dram_a <= MA_W'(addr_q[COL_W-1:0]);
          if (t_exp) begin
            dram_casl_n <= !be_q[0];
            dram_cash_n <= !be_q[1];
            dram_oe_n   <= we_q;
          end
        end
        ST_COL: begin
          if (t_exp) begin
            if (!we_q) host_rdata <= rd_masked;
            host_done   <= 1'b1;
            dram_ras_n  <= 1'b1;
            dram_casl_n <= 1'b1;
            dram_cash_n <= 1'b1;
            dram_oe_n   <= 1'b1;
            dram_we_n   <= 1'b1;
            dq_oe       <= 1'b0;
          end
        end
        ST_RF_CAS: if (t_exp) dram_ras_n <= 1'b0;
        ST_RF_RAS: begin
          if (t_exp) begin
            dram_ras_n  <= 1'b1;
            dram_casl_n <= 1'b1;
            dram_cash_n <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
  parameter int PAUSE_CYC = 50000,
  parameter int WAKE_N    = 8,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 3,
  parameter int T_RAS     = 8,
  parameter int T_RP      = 4,
  parameter int T_CSR     = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       ras_n,
  input logic       casl_n,
  input logic       cash_n,
  input logic       we_n,
  input logic       oe_n,
  input logic       dq_oe,
  input logic [1:0] be_q,
  input logic       done
);
  localparam int CW = $clog2(PAUSE_CYC + T_RAS + T_RP + T_CAS + T_CSR + 2);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] since_rst, ras_lo, ras_hi, casl_lo, cash_lo, cas_lo_pre;
  logic [7:0]    wake_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0; ras_lo <= '0; ras_hi <= CMAX; casl_lo <= '0; cash_lo <= '0;
      cas_lo_pre <= '0; wake_seen <= '0;
    end else begin
      if (since_rst != CMAX) since_rst <= since_rst + 1'b1;
      ras_lo  <= ras_n  ? '0 : ((ras_lo  == CMAX) ? CMAX : ras_lo  + 1'b1);
      ras_hi  <= !ras_n ? '0 : ((ras_hi  == CMAX) ? CMAX : ras_hi  + 1'b1);
      casl_lo <= casl_n ? '0 : ((casl_lo == CMAX) ? CMAX : casl_lo + 1'b1);
      cash_lo <= cash_n ? '0 : ((cash_lo == CMAX) ? CMAX : cash_lo + 1'b1);
      cas_lo_pre <= (ras_n && !casl_n) ? cas_lo_pre + 1'b1 : '0;
      if (ras_n && !casl_n && !cash_n && wake_seen != 8'hff && cas_lo_pre == '0)
        wake_seen <= wake_seen + 1'b1;
    end
  end

  assert_pause_R2: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) || $fell(casl_n) || $fell(cash_n)) |-> since_rst >= CW'(PAUSE_CYC));
  assert_wake_first_R2: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && casl_n && cash_n) |-> wake_seen >= 8'(WAKE_N));
  assert_cbr_setup_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && !casl_n) |-> (!cash_n && cas_lo_pre >= CW'(T_CSR)));
  assert_we_early_R7: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && !we_n && ($fell(casl_n) || $fell(cash_n))) |-> $past(we_n) == 1'b0);
  assert_oe_high_write_R7: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> oe_n);
  assert_drive_write_only_R7: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (!we_n && oe_n && !ras_n));
  assert_lane_lo_R8: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && $fell(casl_n)) |-> be_q[0]);
  assert_lane_hi_R8: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && $fell(cash_n)) |-> be_q[1]);
  assert_ras_low_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> ras_lo >= CW'(T_RAS));
  assert_ras_pre_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> ras_hi >= CW'(T_RP));
  assert_rcd_R10: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && $fell(casl_n)) |-> ras_lo >= CW'(T_RCD));
  assert_casl_width_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(casl_n) |-> casl_lo >= CW'(T_CAS));
  assert_cash_width_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(cash_n) |-> cash_lo >= CW'(T_CAS));
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(
  .PAUSE_CYC(PAUSE_CYC), .WAKE_N(WAKE_N), .T_RCD(T_RCD), .T_CAS(T_CAS),
  .T_RAS(T_RAS), .T_RP(T_RP), .T_CSR(T_CSR)
) u_chk (
  .clk(clk), .rst(rst), .ras_n(dram_ras_n), .casl_n(dram_casl_n),
  .cash_n(dram_cash_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
  .dq_oe(dq_oe), .be_q(be_q), .done(host_done)
);

// File: tb/sim_edo_dram_ctrl.sv
`timescale 1ns/1ps
module sim_edo_dram_ctrl;
  localparam int PAUSE0 = 40, INTV0 = 300, LAPSE0 = 600;
  localparam int PAUSE1 = 10, INTV1 = 4000, LAPSE1 = 100;
  localparam int T_RCD = 3, T_CAS = 3, T_CAC = 4, T_RAS = 8, T_RP = 4, T_CSR = 2;
  localparam int HOLD    = 5;                         // max(T_CAS,T_CAC,T_RAS-T_RCD)
  localparam int BURST   = T_CSR + T_RAS + T_RP + 1;
  localparam int ACC_LEN = T_RCD + HOLD + T_RP;

  logic clk = 0, rst = 1;
  always #2 clk = ~clk;

  logic        req = 0, we = 0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic [15:0] rdata;
  logic        done;
  logic [8:0]  da;
  logic        ras_n, casl_n, cash_n, we_n, oe_n;
  wire  [15:0] dq;

  logic [15:0] rdata1;
  logic        done1;
  logic [8:0]  da1;
  logic        ras1_n, casl1_n, cash1_n, we1_n, oe1_n;
  wire  [15:0] dq1;

  edo_dram_ctrl #(.PAUSE_CYC(PAUSE0), .REF_INTERVAL(INTV0), .REF_LAPSE(LAPSE0),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CAC(T_CAC), .T_RAS(T_RAS), .T_RP(T_RP), .T_CSR(T_CSR))
  u0 (.clk(clk), .rst(rst), .host_req(req), .host_we(we), .host_addr(addr),
    .host_wdata(wdata), .host_be(be), .host_rdata(rdata), .host_done(done),
    .dram_a(da), .dram_ras_n(ras_n), .dram_casl_n(casl_n), .dram_cash_n(cash_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_dq(dq));

  edo_dram_ctrl #(.PAUSE_CYC(PAUSE1), .REF_INTERVAL(INTV1), .REF_LAPSE(LAPSE1),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CAC(T_CAC), .T_RAS(T_RAS), .T_RP(T_RP), .T_CSR(T_CSR))
  u1 (.clk(clk), .rst(rst), .host_req(1'b0), .host_we(1'b0), .host_addr(18'd0),
    .host_wdata(16'd0), .host_be(2'b00), .host_rdata(rdata1), .host_done(done1),
    .dram_a(da1), .dram_ras_n(ras1_n), .dram_casl_n(casl1_n), .dram_cash_n(cash1_n),
    .dram_we_n(we1_n), .dram_oe_n(oe1_n), .dram_dq(dq1));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(bit ok, string req_tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  // DRAM model and strobe monitor (samples at the falling clock edge)
  logic [15:0] mem [int];
  logic [15:0] sh  [int];
  logic [8:0]  mrow = '0, mcol = '0;
  logic [15:0] mrd = '0;
  logic        p_ras = 1, p_casl = 1, p_cash = 1, p_we = 1;
  int          cbr0 [$];
  int          cbr1 [$];
  logic        p_casl1 = 1;
  int          cas_f = 0, ras_f = 0, first_acc = -1;
  logic [17:0] cur_addr = '0;

  assign dq[7:0]  = (!oe_n && !ras_n && !casl_n) ? mrd[7:0]  : 8'bz;
  assign dq[15:8] = (!oe_n && !ras_n && !cash_n) ? mrd[15:8] : 8'bz;

  function automatic logic [15:0] get(ref logic [15:0] m [int], input int k);
    return m.exists(k) ? m[k] : 16'h0;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (p_casl && !casl_n && ras_n) begin
        cbr0.push_back(cyc); cas_f = cyc;
      end
      if (p_ras && !ras_n) begin
        ras_f = cyc;
        if (!casl_n) check(cyc - cas_f >= T_CSR && !cash_n, "R3", cyc - cas_f, T_CSR);
        else begin
          mrow = da;
          if (first_acc < 0) first_acc = cyc;
          check(da == cur_addr[17:9], "R6 row", da, cur_addr[17:9]);
        end
      end
      if (!ras_n && ((p_casl && !casl_n) || (p_cash && !cash_n))) begin
        mcol = da;
        check(da == cur_addr[8:0], "R6 col", da, cur_addr[8:0]);
        check(cyc - ras_f >= T_RCD, "R10 rcd", cyc - ras_f, T_RCD);
        if (!we_n) begin
          check(!p_we && oe_n, "R7 early write", {p_we, oe_n}, 2'b01);
          if (!casl_n) mem[int'({da, mrow})] = {get(mem, int'({da, mrow}))[15:8], dq[7:0]};
          if (!cash_n) mem[int'({da, mrow})] = {dq[15:8], get(mem, int'({da, mrow}))[7:0]};
        end else begin
          mrd = get(mem, int'({da, mrow}));
        end
      end
      if (!p_ras && ras_n && p_casl == p_cash && !(!p_casl && cbr_mode(cas_f, ras_f)))
        check(cyc - ras_f >= T_RAS, "R10 ras", cyc - ras_f, T_RAS);
      p_ras = ras_n; p_casl = casl_n; p_cash = cash_n; p_we = we_n;
      if (p_casl1 && !casl1_n && ras1_n) cbr1.push_back(cyc);
      p_casl1 = casl1_n;
    end
  end

  function automatic bit cbr_mode(int cf, int rf);
    return cf < rf;
  endfunction

  // Scoreboard
  logic [15:0] exp_q [$];
  bit          rd_q  [$];
  logic        p_done = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        check(!p_done, "R12 pulse width", p_done, 0);
        check(exp_q.size() != 0, "R12 unexpected done", 0, 1);
        if (exp_q.size() != 0) begin
          logic [15:0] e;
          bit r;
          e = exp_q.pop_front();
          r = rd_q.pop_front();
          if (r) check(rdata == e, "R9 read data", rdata, e);
        end
      end
      p_done = done;
    end
  end

  task automatic access(bit w, logic [17:0] ad, logic [15:0] wd, logic [1:0] b);
    logic [15:0] old, e;
    old = get(sh, int'(ad));
    if (w) begin
      e = {b[1] ? wd[15:8] : old[15:8], b[0] ? wd[7:0] : old[7:0]};
      sh[int'(ad)] = e;
    end else e = {b[1] ? old[15:8] : 8'h0, b[0] ? old[7:0] : 8'h0};
    exp_q.push_back(e);
    rd_q.push_back(!w);
    cur_addr = ad;
    we = w; addr = ad; wdata = wd; be = b; req = 1;
    do @(negedge clk); while (!done);
    req = 0;
  endtask

  initial begin
    repeat (10) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(ras_n && casl_n && cash_n && we_n && oe_n && !done, "R1 reset state",
          {ras_n, casl_n, cash_n, we_n, oe_n, done}, 6'b111110);

    // request raised during the pause; must wait for the wake-up refreshes
    access(1, 18'h2_A5C3, 16'h1234, 2'b11);
    check(cbr0.size() == 8, "R2 wake count", cbr0.size(), 8);
    check(cbr0[0] >= PAUSE0, "R2 pause", cbr0[0], PAUSE0);
    for (int i = 1; i < 8; i++)
      check(cbr0[i] - cbr0[i-1] == BURST, "R2 wake spacing", cbr0[i] - cbr0[i-1], BURST);
    check(first_acc > cbr0[7], "R2 access after wake", first_acc, cbr0[7]);

    access(0, 18'h2_A5C3, 16'h0, 2'b11);
    access(1, 18'h0_01FF, 16'hBEEF, 2'b11);
    access(0, 18'h0_01FF, 16'h0, 2'b11);
    // byte lanes
    access(1, 18'h2_A5C3, 16'hAA55, 2'b01);   // R8 low lane only
    access(0, 18'h2_A5C3, 16'h0, 2'b11);      // expect 1255
    access(1, 18'h2_A5C3, 16'h77EE, 2'b10);   // R8 high lane only
    access(0, 18'h2_A5C3, 16'h0, 2'b01);      // R9 masked: expect 0055
    access(0, 18'h2_A5C3, 16'h0, 2'b10);      // expect 7700

    // back-to-back traffic longer than the refresh interval (R11)
    begin
      int base;
      base = cbr0.size();
      for (int i = 0; i < 40; i++) begin
        logic [17:0] ad;
        ad = 18'((i * 5237 + 77) & 18'h3FFFF);
        access(1, ad, 16'(i * 2654 + 1), 2'b11);
        access(0, ad, 16'h0, 2'b11);
      end
      check(cbr0.size() > base, "R11 refresh during traffic", cbr0.size(), base + 1);
      for (int i = 9; i < cbr0.size(); i++)
        check(cbr0[i] - cbr0[i-1] <= INTV0 + ACC_LEN + 1 && cbr0[i] - cbr0[i-1] >= INTV0,
              "R11 refresh gap", cbr0[i] - cbr0[i-1], INTV0);
    end

    // idle host: exact spacing (R4)
    repeat (2 * INTV0 + 40) @(negedge clk);
    check(cbr0[cbr0.size()-1] - cbr0[cbr0.size()-2] == INTV0, "R4 idle interval",
          cbr0[cbr0.size()-1] - cbr0[cbr0.size()-2], INTV0);

    // lapse re-run on the second instance (R5)
    check(cbr1.size() >= 16, "R5 burst count", cbr1.size(), 16);
    if (cbr1.size() >= 16) begin
      check(cbr1[8] - cbr1[7] >= LAPSE1, "R5 lapse gap", cbr1[8] - cbr1[7], LAPSE1);
      for (int i = 9; i < 16; i++)
        check(cbr1[i] - cbr1[i-1] == BURST, "R5 rerun spacing", cbr1[i] - cbr1[i-1], BURST);
    end

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R12 all results returned", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule